// File: doc/BRIEF.md
# Configuration load sequence controller

This block sequences the loading of a programmable device's configuration image. It runs from power-up to the hand-off into startup. After a power-up cycle and a timed clear of the configuration memory, it latches the operating mode once. It then scans a stream of 32-bit words for a synchronisation pattern and compares the next word with the expected device identifier. A fixed number of payload words follow, and a CRC-32C is accumulated over them. A check command and a reference value close the load. A good match produces a one-cycle startup request, and the done indication then stays high. A bad identifier or a bad checksum parks the block in an error state.

Two failure paths are modelled. A spurious extra clock edge leaves every later word shifted by one bit, so the check command is never seen. The load then stalls with the init flag high, done low and no error. In the flash-read modes, a read address counter advances or retreats by one per accepted word. When it passes its end and wraps, it forces a fallback restart of the whole sequence. An active-low program request aborts any stage and restarts from power-up. While the boundary-scan port is active, the word interface is shut off.

Top module: `cfg_load_seq`

## Requirements
- R1: After reset is released, `init_b_o` is low for exactly CLEAR_CYCLES+1 cycles (one power-up cycle plus CLEAR_CYCLES clear cycles), and `done_o`, `err_o`, `start_o` and `fallback_o` are low while reset is held.
- R2: No word is interpreted until a word equal to 32'hAA995566 has been accepted; earlier words are discarded.
- R3: The word accepted after the sync pattern is compared with DEVICE_ID. A mismatch raises `err_o`, drops `init_b_o` and keeps both until a program request.
- R4: The CRC is the reflected CRC-32C (polynomial 32'h82F63B78, preset all ones, bit 0 of each word first, no final inversion), taken over the LOAD_WORDS payload words. The check command 32'h30008001 is followed by a value word. When the value matches, `start_o` is high for one cycle after the accepting edge, and `done_o` is high from the next cycle with `init_b_o` high.
- R5: A checksum value mismatch raises `err_o`, drives `init_b_o` low and keeps `done_o` low.
- R6: `mode_i` is sampled once per sequence in the cycle that follows the clear stage. Later changes have no effect.
- R7: While `jtag_active_i` is high, words on `word_i` are ignored.
- R8: A pulse on `dbl_clk_i` rotates every later word left by one bit, with the previous word's bit 31 entering bit 0. A load disturbed this way never recognises the check command: `done_o` stays low, `init_b_o` stays high and `err_o` stays low.
- R9: With mode 3'b010, the flash address starts at 0 and rises by one per accepted word. The accepted word that finds it at its maximum wraps it, pulses `fallback_o` for one cycle and restarts the sequence (`init_b_o` low).
- R10: With mode 3'b011, the flash address starts at its maximum and falls by one per accepted word. The accepted word that finds it at 0 wraps it, with the same fallback pulse and restart.
- R11: `prog_n_i` low aborts the current stage. The sequence restarts with `init_b_o` low for CLEAR_CYCLES+1 cycles, and a pending error is cleared.
- R12: In any mode other than 3'b010 and 3'b011, the flash address stays 0 and no fallback occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_n_i | input | 1 | Active-low program request; restarts the sequence |
| mode_i | input | 3 | Operating mode, sampled once per sequence |
| jtag_active_i | input | 1 | Boundary-scan port active; blocks the word interface |
| dbl_clk_i | input | 1 | Marks a spurious extra clock edge (alignment loss) |
| word_valid_i | input | 1 | Word strobe |
| word_i | input | 32 | Configuration word |
| init_b_o | output | 1 | High when ready and error-free; low while clearing or on error |
| done_o | output | 1 | Load finished and startup entered |
| start_o | output | 1 | One-cycle startup request |
| err_o | output | 1 | Identifier or checksum failure |
| fallback_o | output | 1 | One-cycle pulse on flash address wrap |
| flash_addr_o | output | ADDR_W | Flash read address |

## Verification
Every result is registered once. Error, fallback and address changes appear in the cycle after the edge that accepts the word causing them. The startup request appears in the cycle after the checksum value is accepted, and done follows one cycle later. After reset or a program request, the init flag comes up after CLEAR_CYCLES+1 low cycles. The bench drives each word on a falling edge, returns just after the accepting rising edge and samples outputs on the next falling edge, so each check lands in the exact cycle a result is due. In the wrap tests, the address is also checked one word before the wrap to confirm the fallback is not early.

// File: rtl/cfg_load_pkg.sv
// Shared types and constants for the configuration load sequencer.
package cfg_load_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        ST_POR, ST_CLEAR, ST_SAMPLE, ST_SYNC, ST_IDCHK, ST_LOAD,
        ST_CRCCMD, ST_CRCVAL, ST_START, ST_DONE, ST_ERR
    } cfg_state_e;

    localparam logic [2:0]        MODE_FLASH_UP = 3'b010;
    localparam logic [2:0]        MODE_FLASH_DN = 3'b011;
    localparam logic [WORD_W-1:0] SYNC_PATTERN  = 32'hAA995566;
    localparam logic [WORD_W-1:0] CRC_CHECK_CMD = 32'h30008001;
endpackage

// File: rtl/cfg_crc32c.sv
// Reflected CRC accumulator, one full word per enabled cycle.
// Assumes: clr_i and en_i are not needed in the same cycle (clear wins).
module cfg_crc32c #(
    parameter int           W    = 32,
    parameter logic [W-1:0] POLY = 32'h82F63B78
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] crc_o
);
    function automatic logic [W-1:0] fold(input logic [W-1:0] c, input logic [W-1:0] d);
        logic [W-1:0] r;
        r = c;
        for (int i = 0; i < W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // Preset on clear, fold in one word when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) crc_o <= '1;
        else if (en_i)       crc_o <= fold(crc_o, data_i);
    end

    assert_crc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(crc_o));
endmodule

// File: rtl/cfg_word_align.sv
// Models word alignment: after a slip event each word is seen shifted by
// one bit, with the previous word's top bit entering at bit 0.
// Assumes: clr_i starts a new sequence and restores alignment.
module cfg_word_align #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         slip_i,
    input  logic         accept_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] eff_o,
    output logic         mis_o
);
    logic msb_q;

    assign eff_o = mis_o ? {word_i[W-2:0], msb_q} : word_i;

    // Track the slip flag and the carry bit of the last accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mis_o <= 1'b0;
            msb_q <= 1'b0;
        end else begin
            if (clr_i)       mis_o <= 1'b0;
            else if (slip_i) mis_o <= 1'b1;
            if (accept_i)    msb_q <= word_i[W-1];
        end
    end

    assert_slip_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_o && !clr_i) |=> mis_o);
endmodule

// File: rtl/cfg_flash_addr.sv
// Flash read address counter, rising or falling by one per step, reports
// the step that wraps past the end of the range.
// Assumes: load_i selects the start point from down_i.
module cfg_flash_addr #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              down_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wrap_o
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    assign wrap_o = step_i && (down_i ? (addr_o == '0) : (addr_o == TOP));

    // Load the start point or move one place.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_o <= '0;
        else if (load_i) addr_o <= down_i ? TOP : '0;
        else if (step_i) addr_o <= down_i ? addr_o - 1'b1 : addr_o + 1'b1;
    end

    assert_addr_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !down_i) |=> (addr_o == $past(addr_o) + 1'b1));
    assert_addr_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && down_i) |=> (addr_o == $past(addr_o) - 1'b1));
endmodule

// File: rtl/cfg_load_seq.sv
// Configuration load sequencer: power-up, clear, mode sample, sync search,
// identifier check, payload with CRC, check command and value, startup.
// Assumes: one word per cycle at most; prog_n_i and rst_n are synchronous.
module cfg_load_seq
    import cfg_load_pkg::*;
#(
    parameter int                CLEAR_CYCLES = 8,
    parameter int                LOAD_WORDS   = 4,
    parameter int                ADDR_W       = 5,
    parameter logic [WORD_W-1:0] DEVICE_ID    = 32'h0A1B2C3D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_n_i,
    input  logic [2:0]        mode_i,
    input  logic              jtag_active_i,
    input  logic              dbl_clk_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              init_b_o,
    output logic              done_o,
    output logic              start_o,
    output logic              err_o,
    output logic              fallback_o,
    output logic [ADDR_W-1:0] flash_addr_o
);
    localparam int             CW       = $clog2(CLEAR_CYCLES + 1);
    localparam int             LW       = $clog2(LOAD_WORDS + 1);
    localparam logic [CW-1:0]  CLR_LAST = CW'(CLEAR_CYCLES - 1);
    localparam logic [LW-1:0]  LD_LAST  = LW'(LOAD_WORDS - 1);

    cfg_state_e        st_q, st_d;
    logic [CW-1:0]     clr_cnt;
    logic [LW-1:0]     ld_cnt;
    logic [2:0]        mode_q;
    logic              in_stream, accept, sampling, flash_q, down_sel;
    logic              wrap, mis;
    logic [WORD_W-1:0] eff, crc;

    assign in_stream = (st_q == ST_SYNC) || (st_q == ST_IDCHK) || (st_q == ST_LOAD)
                    || (st_q == ST_CRCCMD) || (st_q == ST_CRCVAL);
    assign accept    = word_valid_i && !jtag_active_i && in_stream;
    assign sampling  = (st_q == ST_SAMPLE);
    assign flash_q   = (mode_q == MODE_FLASH_UP) || (mode_q == MODE_FLASH_DN);
    assign down_sel  = sampling ? (mode_i == MODE_FLASH_DN) : (mode_q == MODE_FLASH_DN);

    cfg_word_align #(.W(WORD_W)) u_align (
        .clk(clk), .rst_n(rst_n), .clr_i(sampling), .slip_i(dbl_clk_i),
        .accept_i(accept), .word_i(word_i), .eff_o(eff), .mis_o(mis)
    );

    cfg_crc32c #(.W(WORD_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr_i(sampling),
        .en_i(accept && (st_q == ST_LOAD)), .data_i(eff), .crc_o(crc)
    );

    cfg_flash_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load_i(sampling), .down_i(down_sel),
        .step_i(accept && flash_q), .addr_o(flash_addr_o), .wrap_o(wrap)
    );

    // Stage sequencing; program request and address wrap restart everything.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_POR:    st_d = ST_CLEAR;
            ST_CLEAR:  if (clr_cnt == CLR_LAST) st_d = ST_SAMPLE;
            ST_SAMPLE: st_d = ST_SYNC;
            ST_SYNC:   if (accept && eff == SYNC_PATTERN) st_d = ST_IDCHK;
            ST_IDCHK:  if (accept) st_d = (eff == DEVICE_ID) ? ST_LOAD : ST_ERR;
            ST_LOAD:   if (accept && ld_cnt == LD_LAST) st_d = ST_CRCCMD;
            ST_CRCCMD: if (accept && eff == CRC_CHECK_CMD) st_d = ST_CRCVAL;
            ST_CRCVAL: if (accept) st_d = (eff == crc) ? ST_START : ST_ERR;
            ST_START:  st_d = ST_DONE;
            default:   st_d = st_q;
        endcase
        if (wrap)      st_d = ST_POR;
        if (!prog_n_i) st_d = ST_POR;
    end

    // State, stage counters, mode latch and fallback pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_POR;
            clr_cnt    <= '0;
            ld_cnt     <= '0;
            mode_q     <= '0;
            fallback_o <= 1'b0;
        end else begin
            st_q       <= st_d;
            clr_cnt    <= (st_q == ST_CLEAR) ? clr_cnt + 1'b1 : '0;
            if (st_q != ST_LOAD)  ld_cnt <= '0;
            else if (accept)      ld_cnt <= ld_cnt + 1'b1;
            if (sampling)         mode_q <= mode_i;
            fallback_o <= wrap && prog_n_i;
        end
    end

    assign init_b_o = !((st_q == ST_POR) || (st_q == ST_CLEAR) || (st_q == ST_ERR));
    assign done_o   = (st_q == ST_DONE);
    assign start_o  = (st_q == ST_START);
    assign err_o    = (st_q == ST_ERR);

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && prog_n_i) |=> (done_o && !start_o));
    assert_done_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && prog_n_i) |=> done_o);
    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && prog_n_i) |=> err_o);
    assert_prog_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_i |=> (!init_b_o && !done_o && !err_o));
    assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_SAMPLE) |=> $stable(mode_q));
    assert_jtag_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (jtag_active_i && !sampling) |=> $stable(flash_addr_o));
    assert_fallback_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fallback_o |-> !init_b_o);
    assert_nonflash_still_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_q && !sampling) |=> $stable(flash_addr_o));
    assert_misalign_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mis && st_q == ST_CRCCMD && !done_o) |=> !done_o);
endmodule

// File: tb/cfg_load_seq_bench.sv
module cfg_load_seq_bench;
    localparam int          CLR   = 8;
    localparam int          AW    = 5;
    localparam logic [31:0] ID    = 32'h0A1B2C3D;
    localparam logic [31:0] SYNCW = 32'hAA995566;
    localparam logic [31:0] CMD   = 32'h30008001;

    logic clk = 0, rst_n = 0, prog_n = 1, jtag = 0, dbl = 0, vld = 0;
    logic [2:0]  mode = 3'b000;
    logic [31:0] wd = '0;
    logic init_b, done, start, err, fb;
    logic [AW-1:0] addr;
    int checks = 0, errors = 0;
    logic [31:0] pay [4] = '{32'h11110000, 32'hDEADBEEF, 32'h00000001, 32'h80000000};

    always #10 clk = ~clk;

    cfg_load_seq u_cfg_load_seq (
        .clk(clk), .rst_n(rst_n), .prog_n_i(prog_n), .mode_i(mode),
        .jtag_active_i(jtag), .dbl_clk_i(dbl), .word_valid_i(vld), .word_i(wd),
        .init_b_o(init_b), .done_o(done), .start_o(start), .err_o(err),
        .fallback_o(fb), .flash_addr_o(addr)
    );

    function automatic logic [31:0] ref_crc();
        logic [31:0] c = '1;
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 32; i++)
                c = (c[0] ^ pay[k][i]) ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] w);
        @(negedge clk); vld = 1; wd = w;
        @(posedge clk); #1; vld = 0;
    endtask

    task automatic wait_init(output int n);
        n = 0;
        while (!init_b && n < 100) begin n++; @(negedge clk); end
    endtask

    task automatic prog_pulse(output int n);
        @(negedge clk); prog_n = 0;
        @(negedge clk); prog_n = 1;
        wait_init(n);
    endtask

    task automatic good_load(input logic [31:0] crcv);
        put(SYNCW); put(ID);
        for (int k = 0; k < 4; k++) put(pay[k]);
        put(CMD); put(crcv);
    endtask

    task automatic t_reset();
        int n;
        @(negedge clk);
        chk("R1 init_b in reset", init_b, 0); chk("R1 done in reset", done, 0);
        chk("R1 err in reset", err, 0);       chk("R1 start in reset", start, 0);
        chk("R1 fallback in reset", fb, 0);
        rst_n = 1;
        wait_init(n);
        chk("R1 init_b low cycles", n, CLR + 1);
    endtask

    task automatic t_good();
        put(32'h12345678); put(32'h0);          // R2 junk before sync
        good_load(ref_crc());
        @(negedge clk);
        chk("R4 start pulse", start, 1); chk("R4 done not yet", done, 0);
        @(negedge clk);
        chk("R4 start ends", start, 0); chk("R4 done", done, 1);
        chk("R4 init_b high", init_b, 1); chk("R2 load ok after junk", err, 0);
        chk("R12 address stays 0", addr, 0); chk("R12 no fallback", fb, 0);
    endtask

    task automatic t_badid();
        int n;
        prog_pulse(n);
        chk("R11 restart low cycles", n, CLR + 1);
        put(SYNCW); put(ID ^ 32'h1);
        @(negedge clk);
        chk("R3 err on bad id", err, 1); chk("R3 init_b low", init_b, 0);
        put(SYNCW); put(ID);
        @(negedge clk);
        chk("R3 err sticky", err, 1); chk("R3 no done", done, 0);
        prog_pulse(n);
        chk("R11 err cleared", err, 0);
    endtask

    task automatic t_badcrc();
        int n;
        good_load(ref_crc() ^ 32'h4);
        @(negedge clk);
        chk("R5 err on crc", err, 1); chk("R5 init_b low", init_b, 0);
        chk("R5 done low", done, 0);
        prog_pulse(n);
    endtask

    task automatic t_abort();
        int n;
        put(SYNCW); put(ID); put(pay[0]); put(pay[1]);
        prog_pulse(n);
        chk("R11 abort low cycles", n, CLR + 1);
        good_load(ref_crc());
        @(negedge clk); @(negedge clk);
        chk("R11 full load after abort", done, 1);
    endtask

    task automatic t_jtag();
        int n;
        prog_pulse(n);
        jtag = 1;
        put(SYNCW); put(ID ^ 32'hFF);
        @(negedge clk);
        chk("R7 words ignored no err", err, 0); chk("R7 init_b high", init_b, 1);
        jtag = 0;
        good_load(ref_crc());
        @(negedge clk); chk("R7 start after release", start, 1);
        @(negedge clk); chk("R7 done after release", done, 1);
    endtask

    task automatic t_mode();
        int n;
        prog_pulse(n);
        @(negedge clk); mode = 3'b010;
        put(SYNCW);
        @(negedge clk); chk("R6 late mode ignored addr", addr, 0);
        put(ID);
        for (int k = 0; k < 4; k++) put(pay[k]);
        put(CMD); put(ref_crc());
        @(negedge clk); @(negedge clk);
        chk("R6 done with late mode", done, 1);
        mode = 3'b000;
    endtask

    task automatic t_misalign();
        int n;
        prog_pulse(n);
        put(SYNCW); put(ID);
        for (int k = 0; k < 4; k++) put(pay[k]);
        @(negedge clk); dbl = 1; @(posedge clk); #1; dbl = 0;
        put(CMD); put(ref_crc()); put(CMD); put(ref_crc());
        @(negedge clk);
        chk("R8 done stays low", done, 0); chk("R8 init_b high", init_b, 1);
        chk("R8 no error", err, 0);
    endtask

    task automatic t_flash(input logic [2:0] m, input string tag,
                           input logic [AW-1:0] after_sync, input logic [AW-1:0] last);
        int n;
        mode = m;
        prog_pulse(n);
        put(SYNCW);
        @(negedge clk); chk({tag, " address after first word"}, addr, after_sync);
        put(ID);
        for (int k = 0; k < 4; k++) put(pay[k]);
        @(negedge clk); dbl = 1; @(posedge clk); #1; dbl = 0;
        for (int k = 0; k < 25; k++) put(32'h0);
        @(negedge clk);
        chk({tag, " no early fallback"}, fb, 0);
        chk({tag, " address before wrap"}, addr, last);
        chk({tag, " init_b before wrap"}, init_b, 1);
        put(32'h0);
        @(negedge clk);
        chk({tag, " fallback pulse"}, fb, 1); chk({tag, " restart"}, init_b, 0);
        @(negedge clk);
        chk({tag, " fallback one cycle"}, fb, 0);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        t_reset();
        t_good();
        t_badid();
        t_badcrc();
        t_abort();
        t_jtag();
        t_mode();
        t_misalign();
        t_flash(3'b010, "R9", 5'd1, 5'd31);
        t_flash(3'b011, "R10", 5'd30, 5'd0);
        mode = 3'b000;
        prog_pulse(n);
        good_load(ref_crc());
        @(negedge clk); @(negedge clk);
        chk("R12 final load done", done, 1);
        chk("R12 final address", addr, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule